// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit with Selectable NaN Policy

This block selects the smaller or the larger of two single-precision (binary32) operands. Before the comparison, each operand can pass through its own absolute-value and negate modifiers. A 2-bit policy field controls how NaN inputs and zeros of opposite sign are handled.

- Policy 0 prefers numbers. A NaN on one side is dropped, two NaNs give a canonical quiet NaN, and a pair of zeros with opposite signs gives +0.
- Policy 1 lets a NaN win. Any NaN input gives a NaN result, and when both inputs are NaN a fixed ranking decides which one comes out.
- Policies 2 and 3 are plain compare-and-select forms and are not commutative. A comparison that involves a NaN is false, and +0 and -0 compare equal. Policy 2 takes the first operand only when it is strictly better. Policy 3 takes the second operand only when it is strictly better.

The selection logic is combinational. The parameter `REG_OUT` (default 1) places one result register after it, so the result is valid one clock after the inputs. The block has no state machine; the only storage is that result register, which clears on reset.

Top module: `fmm_unit`

## Requirements
- R1: Under policy 0 (mode = 2'b00), if exactly one operand is a NaN (exponent all ones, fraction nonzero), the result is the other operand after its modifiers.
- R2: Under policy 0, if both operands are NaN, the result is 32'h7FC00000.
- R3: Under policies 0 and 1 (mode = 2'b01), if both operands are zero with opposite signs, the result is +0 (32'h00000000), whatever op_max and the operand order are.
- R4: Under policies 0 and 1 with no NaN input, the result is the ordered minimum (op_max = 0) or maximum (op_max = 1). Negatives rank below positives, and among negatives the larger magnitude ranks lower. This covers infinities and denormals.
- R5: Under policy 1, if any operand is NaN the result is a NaN. If only one operand is NaN, the result is that operand.
- R6: Under policy 1 with two NaNs, a NaN with the sign clear ranks above one with the sign set. Among NaNs of equal sign, the larger fraction ranks higher when positive and lower when negative. Max returns the higher-ranked NaN and min the lower-ranked one; if the two rank equal, a is returned.
- R7: Under policy 2 (mode = 2'b10), max returns a if a > b and otherwise b. Min returns a if a < b and otherwise b.
- R8: Under policy 3 (mode = 2'b11), max returns b if a < b and otherwise a. Min returns b if a > b and otherwise a.
- R9: Under policies 2 and 3, +0 and -0 compare equal and any comparison with a NaN is false. For such pairs, policy 2 returns b and policy 3 returns a.
- R10: The absolute-value modifier clears an operand's sign bit. The negate modifier then inverts that sign bit. Both are applied before any comparison or selection.
- R11: With REG_OUT = 1, the result appears on the first rising clock edge after the inputs are applied, and the result is 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand a (binary32) |
| op_b | input | 32 | Second operand b (binary32) |
| a_abs | input | 1 | Clear the sign of a |
| a_neg | input | 1 | Invert the sign of a, after the absolute-value modifier |
| b_abs | input | 1 | Clear the sign of b |
| b_neg | input | 1 | Invert the sign of b, after the absolute-value modifier |
| op_max | input | 1 | 1 selects maximum, 0 selects minimum |
| mode | input | 2 | NaN/zero policy: 0 prefer number, 1 NaN wins, 2 pick on a-better test, 3 pick on b-better test |
| result | output | 32 | Selected value |

## Verification
Directed pairs are chosen so that the four policies give different answers on the same inputs.

- A +0/-0 pair in both orders separates the forced +0 of policies 0 and 1 from the order-dependent picks of policies 2 and 3.
- A single NaN separates dropping the NaN (policy 0), returning it (policy 1) and the false-comparison fallbacks (policies 2 and 3).
- Two NaNs with different signs and with different fractions of the same sign exercise the ranking and the canonical NaN.
- Infinities, denormals and modified operands test the ordered compare across sign and magnitude.
- Random operands that are biased toward special exponents and fractions cover the remaining space for every policy and both min and max.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;

    typedef logic [WORD_W-1:0] fp_word_t;

    typedef struct packed {
        logic              sign;
        logic              is_nan;
        logic              is_zero;
        logic [WORD_W-2:0] mag;
    } fp_class_t;

    typedef enum logic [1:0] {
        POL_PREFER_NUM = 2'd0,
        POL_NAN_WINS   = 2'd1,
        POL_PICK_A     = 2'd2,
        POL_PICK_B     = 2'd3
    } mm_policy_e;

    localparam fp_word_t CANON_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
endpackage

// File: rtl/fmm_srcmod.sv
module fmm_srcmod
    import fmm_pkg::*;
(
    input  fp_word_t  raw,
    input  logic      do_abs,
    input  logic      do_neg,
    output fp_word_t  word,
    output fp_class_t cls
);
    logic               sgn;
    logic [EXP_W-1:0]   expo;
    logic [MAN_W-1:0]   frac;

    always_comb begin
        expo        = raw[WORD_W-2 -: EXP_W];
        frac        = raw[MAN_W-1:0];
        sgn         = (raw[WORD_W-1] & ~do_abs) ^ do_neg;
        word        = {sgn, raw[WORD_W-2:0]};
        cls.sign    = sgn;
        cls.is_nan  = (&expo) && (|frac);
        cls.is_zero = ~|raw[WORD_W-2:0];
        cls.mag     = raw[WORD_W-2:0];
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order
    import fmm_pkg::*;
(
    input  fp_class_t ca,
    input  fp_class_t cb,
    output logic      a_lt_b,
    output logic      b_lt_a,
    output logic      a_nan_above,
    output logic      b_nan_above
);
    logic [MAN_W-1:0] fa, fb;
    logic             ordered, both_zero;

    always_comb begin
        fa        = ca.mag[MAN_W-1:0];
        fb        = cb.mag[MAN_W-1:0];
        ordered   = !ca.is_nan && !cb.is_nan;
        both_zero = ca.is_zero && cb.is_zero;
        a_lt_b    = 1'b0;
        b_lt_a    = 1'b0;
        if (ordered && !both_zero) begin
            if (ca.sign != cb.sign) begin
                a_lt_b = ca.sign;
                b_lt_a = cb.sign;
            end else if (!ca.sign) begin
                a_lt_b = ca.mag < cb.mag;
                b_lt_a = cb.mag < ca.mag;
            end else begin
                a_lt_b = ca.mag > cb.mag;
                b_lt_a = cb.mag > ca.mag;
            end
        end
        if (ca.sign != cb.sign) begin
            a_nan_above = !ca.sign;
            b_nan_above = !cb.sign;
        end else if (!ca.sign) begin
            a_nan_above = fa > fb;
            b_nan_above = fb > fa;
        end else begin
            a_nan_above = fa < fb;
            b_nan_above = fb < fa;
        end
    end
endmodule

// File: rtl/fmm_policy.sv
module fmm_policy
    import fmm_pkg::*;
(
    input  mm_policy_e pol,
    input  logic       op_max,
    input  fp_word_t   wa,
    input  fp_word_t   wb,
    input  fp_class_t  ca,
    input  fp_class_t  cb,
    input  logic       a_lt_b,
    input  logic       b_lt_a,
    input  logic       a_nan_above,
    input  logic       b_nan_above,
    output fp_word_t   pick
);
    fp_word_t numeric;

    always_comb begin
        if (ca.is_zero && cb.is_zero)
            numeric = (ca.sign != cb.sign) ? '0 : wa;
        else if (op_max)
            numeric = a_lt_b ? wb : wa;
        else
            numeric = a_lt_b ? wa : wb;

        unique case (pol)
            POL_PREFER_NUM: begin
                if (ca.is_nan && cb.is_nan) pick = CANON_QNAN;
                else if (ca.is_nan)         pick = wb;
                else if (cb.is_nan)         pick = wa;
                else                        pick = numeric;
            end
            POL_NAN_WINS: begin
                if (ca.is_nan && cb.is_nan)
                    pick = op_max ? (b_nan_above ? wb : wa)
                                  : (a_nan_above ? wb : wa);
                else if (ca.is_nan) pick = wa;
                else if (cb.is_nan) pick = wb;
                else                pick = numeric;
            end
            POL_PICK_A: pick = op_max ? (b_lt_a ? wa : wb) : (a_lt_b ? wa : wb);
            POL_PICK_B: pick = op_max ? (a_lt_b ? wb : wa) : (b_lt_a ? wb : wa);
            default:    pick = wa;
        endcase
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              a_abs,
    input  logic              a_neg,
    input  logic              b_abs,
    input  logic              b_neg,
    input  logic              op_max,
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] result
);
    fp_word_t   wa, wb, pick;
    fp_class_t  ca, cb;
    logic       a_lt_b, b_lt_a, a_up, b_up;
    mm_policy_e pol;

    assign pol = mm_policy_e'(mode);

    fmm_srcmod u_mod_a (.raw(op_a), .do_abs(a_abs), .do_neg(a_neg), .word(wa), .cls(ca));
    fmm_srcmod u_mod_b (.raw(op_b), .do_abs(b_abs), .do_neg(b_neg), .word(wb), .cls(cb));

    fmm_order u_order (
        .ca(ca), .cb(cb), .a_lt_b(a_lt_b), .b_lt_a(b_lt_a),
        .a_nan_above(a_up), .b_nan_above(b_up)
    );

    fmm_policy u_policy (
        .pol(pol), .op_max(op_max), .wa(wa), .wb(wb), .ca(ca), .cb(cb),
        .a_lt_b(a_lt_b), .b_lt_a(b_lt_a), .a_nan_above(a_up), .b_nan_above(b_up),
        .pick(pick)
    );

    generate
        if (REG_OUT) begin : g_reg
            fp_word_t res_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= pick;
            end
            assign result = res_q;

            p_one_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == 2'd0 && (ca.is_nan ^ cb.is_nan)) |=>
                    (result == ($past(ca.is_nan) ? $past(wb) : $past(wa))));
            p_canon_nan_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == 2'd0 && ca.is_nan && cb.is_nan) |=> (result == CANON_QNAN));
            p_mixed_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!mode[1] && ca.is_zero && cb.is_zero && (ca.sign != cb.sign)) |=> (result == '0));
            p_nan_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (mode == 2'd1 && (ca.is_nan || cb.is_nan)) |=>
                    ((&result[WORD_W-2 -: EXP_W]) && (|result[MAN_W-1:0])));
            p_pick_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
                mode[1] |=> (result == $past(wa) || result == $past(wb)));
            p_unordered_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (mode[1] && (ca.is_nan || cb.is_nan)) |=>
                    (result == ($past(mode[0]) ? $past(wa) : $past(wb))));
            p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!(a_lt_b && b_lt_a)));
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign result = pick;
        end
    endgenerate
endmodule

// File: tb/test_fmm_unit.sv
module test_fmm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        a_abs = 0, a_neg = 0, b_abs = 0, b_neg = 0, op_max = 0;
    logic [1:0]  mode = '0;
    logic [31:0] result;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fmm_unit i_fmm_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .a_abs(a_abs), .a_neg(a_neg), .b_abs(b_abs), .b_neg(b_neg),
        .op_max(op_max), .mode(mode), .result(result)
    );

    function automatic bit is_nan(logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic longint num_key(logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    function automatic longint nan_key(logic [31:0] v);
        longint m = longint'(v[22:0]);
        return v[31] ? -m : m;
    endfunction

    function automatic logic [31:0] apply_mod(logic [31:0] v, bit ab, bit ng);
        logic [31:0] r = v;
        if (ab) r[31] = 1'b0;
        if (ng) r[31] = ~r[31];
        return r;
    endfunction

    function automatic logic [31:0] reference(logic [31:0] x, logic [31:0] y,
                                              bit mx, int md, output string tag);
        bit xn = is_nan(x), yn = is_nan(y);
        bit gt_xy = !xn && !yn && num_key(x) > num_key(y);
        bit lt_xy = !xn && !yn && num_key(x) < num_key(y);
        logic [31:0] r;
        if (md >= 2) begin
            tag = (xn || yn || (x[30:0] == 0 && y[30:0] == 0)) ? "R9" : (md == 2 ? "R7" : "R8");
            if (md == 2) r = mx ? (gt_xy ? x : y) : (lt_xy ? x : y);
            else         r = mx ? (lt_xy ? y : x) : (gt_xy ? y : x);
            return r;
        end
        if (xn && yn) begin
            if (md == 0) begin tag = "R2"; return 32'h7FC00000; end
            tag = "R6";
            if (mx) return (nan_key(y) > nan_key(x)) ? y : x;
            return (nan_key(y) < nan_key(x)) ? y : x;
        end
        if (xn || yn) begin
            tag = (md == 0) ? "R1" : "R5";
            if (md == 0) return xn ? y : x;
            return xn ? x : y;
        end
        if (x[30:0] == 0 && y[30:0] == 0) begin
            tag = "R3";
            return (x[31] != y[31]) ? 32'h0 : x;
        end
        tag = "R4";
        return mx ? (lt_xy ? y : x) : (lt_xy ? x : y);
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic run(logic [31:0] x, logic [31:0] y, bit mx, int md,
                       bit aa = 0, bit an = 0, bit ba = 0, bit bn = 0);
        string tag;
        logic [31:0] exp;
        op_a = x; op_b = y; op_max = mx; mode = md[1:0];
        a_abs = aa; a_neg = an; b_abs = ba; b_neg = bn;
        exp = reference(apply_mod(x, aa, an), apply_mod(y, ba, bn), mx, md, tag);
        if (aa | an | ba | bn) tag = {tag, "/R10"};
        @(posedge clk);
        @(negedge clk);
        check({tag, "/R11"}, result, exp);
    endtask

    function automatic logic [31:0] rnd_op();
        logic [31:0] v = $urandom;
        case ($urandom % 6)
            0: v[30:23] = 8'hFF;
            1: v[30:23] = 8'h00;
            2: v[30:0]  = '0;
            3: begin v[30:23] = 8'hFF; v[22:0] = '0; end
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        #20000000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int md = 0; md < 4; md++) begin
            for (int mx = 0; mx < 2; mx++) begin
                run(32'h00000000, 32'h80000000, mx[0], md);   // R3 / R9 zeros
                run(32'h80000000, 32'h00000000, mx[0], md);
                run(32'h7FC00001, 32'h3F800000, mx[0], md);   // single NaN R1 R5
                run(32'hBF800000, 32'hFF800005, mx[0], md);
                run(32'h7F800010, 32'hFF800020, mx[0], md);   // R6 signs differ
                run(32'h7F800010, 32'h7F800020, mx[0], md);   // R6 positive fractions
                run(32'hFF800010, 32'hFF800020, mx[0], md);   // R6 negative fractions
                run(32'h7F800000, 32'hFF800000, mx[0], md);   // R4 infinities
                run(32'h00000001, 32'h80000002, mx[0], md);   // R4 denormals
                run(32'hC0000000, 32'hC0400000, mx[0], md);
                run(32'h3F800000, 32'h3F800000, mx[0], md, 0, 1, 1, 0); // R10
                run(32'hC0000000, 32'h40400000, mx[0], md, 1, 1, 0, 0);
            end
        end
        for (int i = 0; i < 4000; i++)
            run(rnd_op(), rnd_op(), $urandom % 2, $urandom % 4,
                $urandom % 4 == 0, $urandom % 4 == 0, $urandom % 4 == 0, $urandom % 4 == 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset again", result, 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule